// File: doc/BRIEF.md
# Triggered Pipeline Address Controller

This block steers the addressing of a circular sample store of 192 cells, one cell written per clock cycle. A write pointer walks the ring and is presented on `wr_addr_o` so that the storage array knows where the current sample goes. When a trigger arrives, the block works out which cells hold the samples taken a programmed number of cycles earlier. It locks those cells against overwriting and queues their addresses for a downstream reader.

The reader sees a valid/acknowledge handshake. Each queued entry carries one cell address, and each acknowledge releases that cell back to the ring. The operating mode sets how many cells a trigger takes and how they are chosen. A single cell gives the peak sample. Three adjacent cells feed a later weighted combination. In the burst mode, back-to-back triggers walk along adjacent cells so that each one is read out as its own frame.

Top module: `trig_pipe_addr_ctrl`

## Requirements
- R1: While reset is held and in the cycle after its synchronised release, `wr_addr_o` is 0, `rd_valid_o` is 0 and `ovf_o` is 0. The latency register resets to 0.
- R2: With no locked cell ahead, `wr_addr_o` rises by one on every clock and wraps from 191 to 0.
- R3: The write pointer moves to the next cell, in ring order, that is not locked after this edge's updates. A locked cell is never shown on `wr_addr_o`.
- R4: `mode_i` = 0 (peak) or 3 (treated as peak) queues one entry. Its cell is (W − L) mod 192, where W is `wr_addr_o` and L is the latency register, both as they stand before the triggering edge.
- R5: `mode_i` = 1 (three-cell) queues three entries in the order c−2, c−1, c (mod 192), where c = (W − L) mod 192.
- R6: `mode_i` = 2 (burst) queues one entry. If the previous clock also had a burst-mode trigger, the cell is the previous trigger's cell + 1 (mod 192). Otherwise it is (W − L) mod 192.
- R7: `lat_we_i` loads `lat_wdata_i` into the latency register, with values above 160 stored as 160. A trigger on the same edge still uses the old value.
- R8: The queue holds 32 entries, so ten three-cell events fit. A trigger whose entries exceed the free space is dropped whole, and `ovf_o` goes high and stays high until reset.
- R9: `rd_valid_o` is high while the queue is not empty, and `rd_addr_o` is the oldest entry. `rd_ack_i` with `rd_valid_o` high removes that entry. An acknowledge while the queue is empty has no effect.
- R10: An acknowledged cell is unlocked unless another queued entry, or an entry queued on the same edge, holds the same cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Trigger, one per clock |
| mode_i | input | 2 | 0 peak, 1 three-cell, 2 burst, 3 as peak |
| lat_we_i | input | 1 | Latency register write strobe |
| lat_wdata_i | input | 8 | Latency value in cycles |
| wr_addr_o | output | 8 | Cell being written this cycle |
| rd_valid_o | output | 1 | Queued entry available |
| rd_addr_o | output | 8 | Cell address of oldest queued entry |
| rd_ack_i | input | 1 | Consume oldest entry and release its cell |
| ovf_o | output | 1 | Sticky trigger-dropped flag |

## Verification
The hardest situation to reach is the write pointer skipping locked cells. It only happens when locked cells sit in front of the pointer, which needs a long latency and a slow reader, so that entries stay queued until the pointer wraps around to them. Shared cells between overlapping three-cell events (R10) add to this: they only matter when an acknowledge releases one event while a neighbour still holds the same cell. The stimulus reaches these states with directed runs at latency 160 and no acknowledges, and with random phases that bias the trigger rate up and the acknowledge rate down. A bench reference model tracks the lock mask, the queue and the pointer cycle by cycle.

// File: rtl/tpac_pkg.sv
package tpac_pkg;

  typedef enum logic [1:0] {
    MODE_PEAK  = 2'd0,
    MODE_TRIO  = 2'd1,
    MODE_BURST = 2'd2,
    MODE_SPARE = 2'd3
  } tpac_mode_e;

  // Ring arithmetic on cell indices; operands are below n.
  function automatic int ring_add(input int a, input int b, input int n);
    return (a + b) % n;
  endfunction

  function automatic int ring_sub(input int a, input int b, input int n);
    return (a - b + n) % n;
  endfunction

endpackage

// File: rtl/tpac_addr_calc.sv
module tpac_addr_calc #(
  parameter int DEPTH = 192,
  parameter int AW    = 8,
  parameter int LW    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig,
  input  tpac_pkg::tpac_mode_e mode,
  input  logic [AW-1:0]        wr_ptr,
  input  logic [LW-1:0]        lat,
  output logic [1:0]           n_cells,
  output logic [2:0][AW-1:0]   cells
);
  import tpac_pkg::*;

  logic [AW-1:0] last_q, last_d;
  logic          prev_burst_q, prev_burst_d;
  logic [AW-1:0] base;

  always_comb begin
    if (mode == MODE_BURST && prev_burst_q)
      base = AW'(ring_add(int'(last_q), 1, DEPTH));
    else
      base = AW'(ring_sub(int'(wr_ptr), int'(lat), DEPTH));

    if (mode == MODE_TRIO) begin
      n_cells  = 2'd3;
      cells[0] = AW'(ring_sub(int'(base), 2, DEPTH));
      cells[1] = AW'(ring_sub(int'(base), 1, DEPTH));
      cells[2] = base;
    end else begin
      n_cells  = 2'd1;
      cells[0] = base;
      cells[1] = base;
      cells[2] = base;
    end

    last_d       = trig ? base : last_q;
    prev_burst_d = trig && (mode == MODE_BURST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q       <= '0;
      prev_burst_q <= 1'b0;
    end else begin
      last_q       <= last_d;
      prev_burst_q <= prev_burst_d;
    end
  end

  // R6: a consecutive burst trigger follows the previously chosen cell
  p_burst_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode == MODE_BURST && prev_burst_q) |=>
      (int'(last_q) == ring_add(int'($past(last_q)), 1, DEPTH)));

endmodule

// File: rtl/tpac_lock_ring.sv
module tpac_lock_ring #(
  parameter int DEPTH  = 192,
  parameter int AW     = 8,
  parameter int SEARCH = 33
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         set_n,
  input  logic [2:0][AW-1:0] set_cells,
  input  logic               clr_en,
  input  logic [AW-1:0]      clr_addr,
  output logic [AW-1:0]      wr_ptr
);
  import tpac_pkg::*;

  logic [DEPTH-1:0] lock_q, lock_d;
  logic [AW-1:0]    wr_q, wr_d;

  always_comb begin : p_lock_next
    lock_d = lock_q;
    if (clr_en) lock_d[clr_addr] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (k < int'(set_n)) lock_d[set_cells[k]] = 1'b1;
    end
  end

  always_comb begin : p_search
    int  idx;
    logic found;
    found = 1'b0;
    wr_d  = wr_q;
    for (int i = 1; i <= SEARCH; i++) begin
      idx = ring_add(int'(wr_q), i, DEPTH);
      if (!found && !lock_d[idx]) begin
        found = 1'b1;
        wr_d  = AW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      wr_q   <= '0;
    end else begin
      lock_q <= lock_d;
      wr_q   <= wr_d;
    end
  end

  assign wr_ptr = wr_q;

  // R3: the cell under the write pointer is never reserved
  p_wr_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q[wr_q]);

  // R2: the pointer stays inside the ring
  p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_q) < DEPTH);

endmodule

// File: rtl/tpac_event_fifo.sv
module tpac_event_fifo #(
  parameter int FDEPTH = 32,
  parameter int AW     = 8,
  parameter int CW     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         push_n,
  input  logic [2:0][AW-1:0] push_data,
  input  logic               pop,
  output logic [AW-1:0]      head,
  output logic [CW-1:0]      count,
  output logic               head_shared
);
  localparam int PW = (FDEPTH > 1) ? $clog2(FDEPTH) : 1;

  logic [AW-1:0] mem_q [FDEPTH];
  logic [AW-1:0] mem_d [FDEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0][PW-1:0] widx;

  always_comb begin : p_next
    mem_d = mem_q;
    for (int k = 0; k < 3; k++) begin
      widx[k] = PW'((int'(wp_q) + k) % FDEPTH);
      if (k < int'(push_n)) mem_d[widx[k]] = push_data[k];
    end
    wp_d  = PW'((int'(wp_q) + int'(push_n)) % FDEPTH);
    rp_d  = pop ? PW'((int'(rp_q) + 1) % FDEPTH) : rp_q;
    cnt_d = cnt_q + CW'(push_n) - CW'(pop);
  end

  always_comb begin : p_share
    head_shared = 1'b0;
    for (int j = 1; j < FDEPTH; j++) begin
      if (j < int'(cnt_q) && mem_q[(int'(rp_q) + j) % FDEPTH] == mem_q[rp_q])
        head_shared = 1'b1;
    end
    for (int k = 0; k < 3; k++) begin
      if (k < int'(push_n) && push_data[k] == mem_q[rp_q]) head_shared = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = mem_q[rp_q];
  assign count = cnt_q;

  // R8: occupancy never exceeds the queue size
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= FDEPTH);

  // R9: a lone pop removes exactly one entry
  p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push_n == 2'd0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/trig_pipe_addr_ctrl.sv
module trig_pipe_addr_ctrl #(
  parameter int DEPTH   = 192,
  parameter int MAX_LAT = 160,
  parameter int FDEPTH  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       trig_i,
  input  logic [1:0]                 mode_i,
  input  logic                       lat_we_i,
  input  logic [$clog2(DEPTH)-1:0]   lat_wdata_i,
  output logic [$clog2(DEPTH)-1:0]   wr_addr_o,
  output logic                       rd_valid_o,
  output logic [$clog2(DEPTH)-1:0]   rd_addr_o,
  input  logic                       rd_ack_i,
  output logic                       ovf_o
);
  import tpac_pkg::*;

  localparam int AW     = $clog2(DEPTH);
  localparam int LW     = AW;
  localparam int CW     = $clog2(FDEPTH + 1);
  localparam int SEARCH = FDEPTH + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_i    <= rst_s1_q;
    end
  end

  logic [LW-1:0]      lat_q, lat_d;
  logic               ovf_q, ovf_d;
  logic [1:0]         n_cells, push_n;
  logic [2:0][AW-1:0] cells;
  logic [AW-1:0]      wr_ptr, head;
  logic [CW-1:0]      count;
  logic               head_shared, accept, pop;
  tpac_mode_e         mode;

  assign mode = tpac_mode_e'(mode_i);

  tpac_addr_calc #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) i_calc (
    .clk(clk), .rst_n(rst_i), .trig(trig_i), .mode(mode),
    .wr_ptr(wr_ptr), .lat(lat_q), .n_cells(n_cells), .cells(cells)
  );

  always_comb begin : p_ctrl
    accept = trig_i && (CW'(n_cells) <= CW'(FDEPTH) - count);
    push_n = accept ? n_cells : 2'd0;
    pop    = rd_ack_i && (count != '0);
    ovf_d  = ovf_q || (trig_i && !accept);
    if (lat_we_i)
      lat_d = (int'(lat_wdata_i) > MAX_LAT) ? LW'(MAX_LAT) : lat_wdata_i;
    else
      lat_d = lat_q;
  end

  tpac_event_fifo #(.FDEPTH(FDEPTH), .AW(AW), .CW(CW)) i_fifo (
    .clk(clk), .rst_n(rst_i), .push_n(push_n), .push_data(cells),
    .pop(pop), .head(head), .count(count), .head_shared(head_shared)
  );

  tpac_lock_ring #(.DEPTH(DEPTH), .AW(AW), .SEARCH(SEARCH)) i_ring (
    .clk(clk), .rst_n(rst_i), .set_n(push_n), .set_cells(cells),
    .clr_en(pop && !head_shared), .clr_addr(head), .wr_ptr(wr_ptr)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      lat_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      ovf_q <= ovf_d;
    end
  end

  assign wr_addr_o  = wr_ptr;
  assign rd_valid_o = (count != '0);
  assign rd_addr_o  = head;
  assign ovf_o      = ovf_q;

  // R8: the overflow flag never clears outside reset
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_i)
    ovf_q |=> ovf_q);

  // R7: stored latency stays within the window
  p_lat_clamp_r7: assert property (@(posedge clk) disable iff (!rst_i)
    int'(lat_q) <= MAX_LAT);

  // R9: acknowledge on an empty queue leaves it empty without a push
  p_empty_ack_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_ack_i && !rd_valid_o && !trig_i) |=> !rd_valid_o);

endmodule

// File: tb/test_trig_pipe_addr_ctrl.sv
module test_trig_pipe_addr_ctrl;
  localparam int DEPTH = 192;
  localparam int MAXL  = 160;
  localparam int FD    = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       lat_we = 1'b0;
  logic [7:0] lat_wdata = 8'd0;
  logic       ack = 1'b0;
  logic [7:0] wr_addr, rd_addr;
  logic       rd_valid, ovf;

  always #5 clk = ~clk;

  trig_pipe_addr_ctrl i_trig_pipe_addr_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .mode_i(mode),
    .lat_we_i(lat_we), .lat_wdata_i(lat_wdata), .wr_addr_o(wr_addr),
    .rd_valid_o(rd_valid), .rd_addr_o(rd_addr), .rd_ack_i(ack), .ovf_o(ovf)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference model state
  int mq [FD];
  int mcnt, mW, mL, mlast;
  bit mlock [DEPTH];
  bit movf, mprev;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rsub(input int a, input int b);
    return (a - b + DEPTH) % DEPTH;
  endfunction

  task automatic model_step();
    int base, n, head;
    int c [3];
    bit pop, acc, shared;
    pop  = ack && (mcnt > 0);
    head = mq[0];
    if (mode == 2'd2 && mprev) base = (mlast + 1) % DEPTH;
    else base = rsub(mW, mL);
    if (mode == 2'd1) begin
      n = 3; c[0] = rsub(base, 2); c[1] = rsub(base, 1); c[2] = base;
    end else begin
      n = 1; c[0] = base; c[1] = base; c[2] = base;
    end
    acc = trig && (n <= FD - mcnt);
    if (trig && !acc) movf = 1;
    shared = 0;
    for (int j = 1; j < mcnt; j++) if (mq[j] == head) shared = 1;
    if (acc) for (int k = 0; k < n; k++) if (c[k] == head) shared = 1;
    if (trig) mlast = base;
    mprev = trig && (mode == 2'd2);
    if (pop) begin
      for (int j = 0; j < FD - 1; j++) mq[j] = mq[j+1];
      mcnt--;
      if (!shared) mlock[head] = 0;
    end
    if (acc) for (int k = 0; k < n; k++) begin
      mq[mcnt] = c[k]; mcnt++; mlock[c[k]] = 1;
    end
    for (int i = 1; i <= FD + 1; i++) begin
      if (!mlock[(mW + i) % DEPTH]) begin mW = (mW + i) % DEPTH; break; end
    end
    if (lat_we) mL = (int'(lat_wdata) > MAXL) ? MAXL : int'(lat_wdata);
  endtask

  task automatic compare();
    chk("R2 R3 R10 wr_addr", int'(wr_addr), mW);
    chk("R9 rd_valid", int'(rd_valid), int'(mcnt > 0));
    if (mcnt > 0) chk("R4 R5 R6 R9 rd_addr", int'(rd_addr), mq[0]);
    chk("R8 ovf", int'(ovf), int'(movf));
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    trig = 0; ack = 0; lat_we = 0;
  endtask

  task automatic set_lat(input int v);
    lat_we = 1; lat_wdata = 8'(v); step(); lat_we = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : main
    int w0, c0, seen;
    void'($urandom(32'd1234));
    mcnt = 0; mW = 0; mL = 0; mlast = 0; movf = 0; mprev = 0;
    for (int i = 0; i < DEPTH; i++) mlock[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 wr_addr in reset", int'(wr_addr), 0);
    chk("R1 rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 wr_addr after release", int'(wr_addr), 0);
    chk("R1 ovf after release", int'(ovf), 0);
    chk("R1 rd_valid after release", int'(rd_valid), 0);

    // R2: free-running wrap
    idle();
    repeat (191) step();
    chk("R2 wr_addr at ring end", int'(wr_addr), 191);
    step();
    chk("R2 wr_addr wrapped", int'(wr_addr), 0);

    // R9: acknowledge while empty
    ack = 1; step(); ack = 0;
    chk("R9 empty ack ignored", int'(rd_valid), 0);

    // R7: clamp, then peak trigger
    set_lat(255);
    w0 = int'(wr_addr);
    trig = 1; mode = 2'd0; step(); trig = 0;
    chk("R7 R4 clamped peak cell", int'(rd_addr), rsub(w0, 160));
    ack = 1; step(); ack = 0;

    // R7: latency written on the trigger edge applies later
    set_lat(10);
    w0 = int'(wr_addr);
    trig = 1; lat_we = 1; lat_wdata = 8'd40; step(); idle();
    chk("R7 same-edge uses old latency", int'(rd_addr), rsub(w0, 10));
    ack = 1; step(); ack = 0;

    // R5: three-cell order
    w0 = int'(wr_addr);
    c0 = rsub(w0, 40);
    trig = 1; mode = 2'd1; step(); trig = 0;
    chk("R5 first cell", int'(rd_addr), rsub(c0, 2));
    ack = 1; step();
    chk("R5 second cell", int'(rd_addr), rsub(c0, 1));
    step();
    chk("R5 third cell", int'(rd_addr), c0);
    step(); ack = 0;

    // R6: burst of consecutive triggers
    set_lat(5);
    w0 = int'(wr_addr);
    mode = 2'd2; trig = 1; repeat (4) step(); trig = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R6 burst cell", int'(rd_addr), (rsub(w0, 5) + k) % DEPTH);
      ack = 1; step(); ack = 0;
    end

    // R8: eleven three-cell events without readout
    mode = 2'd1; trig = 1; repeat (11) step(); trig = 0;
    chk("R8 overflow flagged", int'(ovf), 1);
    seen = 0;
    ack = 1;
    while (rd_valid && seen < 40) begin step(); seen++; end
    ack = 0;
    chk("R8 ten events held", seen, 30);

    // R3: locked cell ahead of the pointer is skipped
    set_lat(160);
    w0 = int'(wr_addr);
    c0 = rsub(w0, 160);
    mode = 2'd0; trig = 1; step(); trig = 0;
    seen = 0;
    repeat (60) begin step(); if (int'(wr_addr) == c0) seen++; end
    chk("R3 locked cell never written", seen, 0);
    ack = 1; step(); ack = 0;

    // R10: overlapping three-cell events then partial readout
    set_lat(20);
    mode = 2'd1; trig = 1; repeat (2) step(); trig = 0;
    ack = 1; repeat (3) step(); ack = 0;
    repeat (200) step();
    ack = 1; repeat (3) step(); ack = 0;

    // constrained random phases
    for (int ph = 0; ph < 8; ph++) begin
      int tp, ap;
      tp = (ph % 2) ? 40 : 12;
      ap = (ph % 4 == 1) ? 5 : 55;
      for (int cyc = 0; cyc < 2500; cyc++) begin
        trig = ($urandom % 100) < tp;
        mode = 2'($urandom % 4);
        ack  = ($urandom % 100) < ap;
        lat_we = ($urandom % 60) == 0;
        lat_wdata = (ph >= 4) ? 8'(150 + $urandom % 106) : 8'($urandom);
        step();
      end
    end
    idle();
    step();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule